// File: doc/BRIEF.md
# Stereo ADC DC-Removal and Polarity Stage

This block removes the DC component from a stereo stream of signed 16-bit ADC samples and can invert the sign of either channel. Left and right samples arrive together under one valid strobe. For each channel, a first-order highpass subtracts a running DC estimate from the sample. The estimate comes from a leaky integrator. Each filter is switched on or off through a two-bit enable encoding.

When a channel's filter is off, a store bit picks what happens to its estimate. The estimate is either frozen and still subtracted, or cleared so that the channel passes through unchanged. Inversion comes after the highpass, and every arithmetic step saturates. The results are registered once, so the output strobe follows the input strobe by one cycle. All control inputs are meant to be static register bits that change only between samples.

Top module: `adc_hp_polarity`

## Requirements
- R1: With `side_sel_i`=0, `hp_off_i`=0 enables the highpass on both channels and `hp_off_i`=1 disables it on both.
- R2: With `side_sel_i`=1, `hp_off_i`=0 enables the highpass on the left channel only, and `hp_off_i`=1 enables it on the right channel only.
- R3: A disabled channel with `store_ofs_i`=1 keeps its last DC estimate E and outputs x-E (saturated) for every sample x.
- R4: A disabled channel with `store_ofs_i`=0 has its estimate cleared to zero and outputs its input unchanged (before inversion).
- R5: `pol_i` bit 0 inverts the left output and bit 1 inverts the right output: 00 none, 01 left, 10 right, 11 both. Inversion is applied after the highpass.
- R6: Subtraction and inversion saturate to [-32768, 32767]. In particular, inverting -32768 gives 32767, so an inverted channel never outputs -32768.
- R7: `valid_o` is `valid_i` delayed by exactly one clock.
- R8: Without `valid_i`, the data outputs and the DC estimates keep their values.
- R9: Per accepted sample, with est = acc >>> SHIFT_K (arithmetic shift, SHIFT_K=10 by default), the output is x - est, and an enabled channel then updates acc += x - est. After reset, acc = 0.
- R10: After reset, the outputs and `valid_o` are 0. With all controls at 0, both filters run, with no offset storage and no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample pair strobe |
| left_i | input | 16 | Left sample, signed |
| right_i | input | 16 | Right sample, signed |
| side_sel_i | input | 1 | 0: hp_off_i acts on both channels; 1: hp_off_i picks the filtered side |
| hp_off_i | input | 1 | Highpass disable / side choice |
| store_ofs_i | input | 1 | 1: hold estimate while filter off; 0: clear it |
| pol_i | input | 2 | Inversion, bit 0 left, bit 1 right |
| valid_o | output | 1 | Output strobe |
| left_o | output | 16 | Left result, signed |
| right_o | output | 16 | Right result, signed |

## Verification
Some properties are checked on every cycle by the assertions. These are the one-cycle strobe latency and the hold of the outputs between strobes. They also cover exact pass-through and saturated inversion with both filters off and cleared, and the absence of -32768 on any inverted output. The filter arithmetic depends on state built up over thousands of samples, so only the bench scenarios can show it. The same holds for the hold-versus-clear choice for the estimate and the one-sided enable modes. The bench compares every sample against a model of the integrator and checks that a DC input decays toward zero.

// File: rtl/adc_hp_pkg.sv
package adc_hp_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_L = 0;
  localparam int unsigned CH_R = 1;
  typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/hp_mode_decode.sv
module hp_mode_decode
  import adc_hp_pkg::*;
(
  input  logic     side_sel_i,
  input  logic     hp_off_i,
  output ch_mask_t en_o
);
  always_comb begin
    if (side_sel_i) begin
      en_o[CH_L] = ~hp_off_i;
      en_o[CH_R] = hp_off_i;
    end else begin
      en_o[CH_L] = ~hp_off_i;
      en_o[CH_R] = ~hp_off_i;
    end
  end
endmodule

// File: rtl/dc_offset_est.sv
module dc_offset_est #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_K = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     en_i,
  input  logic                     store_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] est_o
);
  localparam int unsigned ACC_W = DATA_W + SHIFT_K + 1;

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_sh;
  logic signed [ACC_W-1:0]  x_ext;
  logic signed [DATA_W-1:0] est_raw;

  assign acc_sh  = acc_q >>> SHIFT_K;
  assign est_raw = acc_sh[DATA_W-1:0];
  assign x_ext   = {{(ACC_W-DATA_W){x_i[DATA_W-1]}}, x_i};
  // a cleared estimate is seen as zero at once
  assign est_o   = (en_i || store_i) ? est_raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (!en_i && !store_i) begin
      acc_q <= '0;
    end else if (valid_i && en_i) begin
      acc_q <= acc_q + x_ext - acc_sh;
    end
  end
endmodule

// File: rtl/hp_sat_path.sv
module hp_sat_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] est_i,
  input  logic                     inv_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0]   diff;
  logic signed [DATA_W-1:0] hp_y;

  assign diff = {x_i[DATA_W-1], x_i} - {est_i[DATA_W-1], est_i};

  always_comb begin
    if (diff[DATA_W] != diff[DATA_W-1]) hp_y = diff[DATA_W] ? MIN_V : MAX_V;
    else                                hp_y = diff[DATA_W-1:0];
  end

  always_comb begin
    if (!inv_i)              y_o = hp_y;
    else if (hp_y == MIN_V)  y_o = MAX_V;
    else                     y_o = -hp_y;
  end
endmodule

// File: rtl/adc_hp_polarity.sv
module adc_hp_polarity
  import adc_hp_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_K = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic                     side_sel_i,
  input  logic                     hp_off_i,
  input  logic                     store_ofs_i,
  input  logic [1:0]               pol_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o
);
  ch_mask_t                 ch_en;
  logic signed [DATA_W-1:0] x_ch   [NUM_CH];
  logic signed [DATA_W-1:0] est_ch [NUM_CH];
  logic signed [DATA_W-1:0] y_ch   [NUM_CH];
  logic signed [DATA_W-1:0] out_q  [NUM_CH];
  logic                     valid_q;

  assign x_ch[CH_L] = left_i;
  assign x_ch[CH_R] = right_i;

  hp_mode_decode u_dec (
    .side_sel_i (side_sel_i),
    .hp_off_i   (hp_off_i),
    .en_o       (ch_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dc_offset_est #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) u_est (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .en_i    (ch_en[c]),
      .store_i (store_ofs_i),
      .x_i     (x_ch[c]),
      .est_o   (est_ch[c])
    );

    hp_sat_path #(.DATA_W(DATA_W)) u_path (
      .x_i   (x_ch[c]),
      .est_i (est_ch[c]),
      .inv_i (pol_i[c]),
      .y_o   (y_ch[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q[c] <= '0;
      else if (valid_i) out_q[c] <= y_ch[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign left_o  = out_q[CH_L];
  assign right_o = out_q[CH_R];
endmodule

// File: rtl/adc_hp_polarity_chk.sv
module adc_hp_polarity_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] left_i,
  input logic signed [DATA_W-1:0] right_i,
  input logic                     side_sel_i,
  input logic                     hp_off_i,
  input logic                     store_ofs_i,
  input logic [1:0]               pol_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] left_o,
  input logic signed [DATA_W-1:0] right_o
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic all_clear;
  assign all_clear = !side_sel_i && hp_off_i && !store_ofs_i;

  a_r7_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r7_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(left_o) && $stable(right_o)));
  a_r4_clear_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && all_clear && pol_i == 2'b00) |=>
      (left_o == $past(left_i) && right_o == $past(right_i)));
  a_r5_invert_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && all_clear && pol_i == 2'b11) |=>
      (left_o  == (($past(left_i)  == MIN_V) ? MAX_V : -$past(left_i)) &&
       right_o == (($past(right_i) == MIN_V) ? MAX_V : -$past(right_i))));
  a_r6_inv_left_no_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pol_i[0]) |=> (left_o != MIN_V));
  a_r6_inv_right_no_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pol_i[1]) |=> (right_o != MIN_V));
endmodule

bind adc_hp_polarity adc_hp_polarity_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/adc_hp_polarity_tb_top.sv
module adc_hp_polarity_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  K = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] left_i = '0, right_i = '0;
  logic side_sel = 1'b0, hp_off = 1'b0, store = 1'b0;
  logic [1:0] pol = 2'b00;
  logic valid_o;
  logic signed [15:0] left_o, right_o;

  int checks = 0;
  int errors = 0;
  longint acc_m [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_hp_polarity dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .left_i(left_i), .right_i(right_i),
    .side_sel_i(side_sel), .hp_off_i(hp_off), .store_ofs_i(store), .pol_i(pol),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic bit ch_en(input int ch);
    if (!side_sel) return !hp_off;
    return (ch == 0) ? !hp_off : hp_off;
  endfunction

  function automatic longint model(input int ch, input longint x);
    longint est, y;
    bit en = ch_en(ch);
    est = (en || store) ? (acc_m[ch] >>> K) : 0;
    y = sat16(x - est);
    if (pol[ch]) y = sat16(-y);
    if (en) acc_m[ch] = acc_m[ch] + x - (acc_m[ch] >>> K);
    else if (!store) acc_m[ch] = 0;
    return y;
  endfunction

  task automatic set_ctrl(input bit s, input bit h, input bit st, input logic [1:0] p);
    @(negedge clk);
    side_sel = s; hp_off = h; store = st; pol = p;
    for (int c = 0; c < 2; c++) if (!ch_en(c) && !store) acc_m[c] = 0;
  endtask

  // one sample pair; returns outputs; checks against the model (R9)
  task automatic send(input longint l, input longint r, input string req,
                      output longint lo, output longint ro);
    longint el, er;
    @(negedge clk);
    left_i = 16'(l); right_i = 16'(r); valid_i = 1'b1;
    el = model(0, l); er = model(1, r);
    @(negedge clk);
    valid_i = 1'b0;
    lo = left_o; ro = right_o;
    check({req, " R7 valid"}, valid_o, 1);
    check({req, " left"}, lo, el);
    check({req, " right"}, ro, er);
  endtask

  task automatic t_reset;
    check("R10 reset valid_o", valid_o, 0);
    check("R10 reset left_o", left_o, 0);
    check("R10 reset right_o", right_o, 0);
  endtask

  task automatic t_default_filter;
    longint lo, ro;
    send(1000, -2000, "R10 first sample", lo, ro);
    check("R10 first left unfiltered", lo, 1000);
    for (int i = 0; i < 4000; i++) send(1000, -2000, "R9 R1 dc", lo, ro);
    check("R9 left dc decayed", (lo <= 30 && lo >= 0) ? 1 : 0, 1);
    check("R9 right dc decayed", (ro >= -60 && ro <= 0) ? 1 : 0, 1);
  endtask

  task automatic t_store_hold;
    longint lo, ro, d0, d1;
    set_ctrl(0, 0, 0, 2'b00);
    for (int i = 0; i < 300; i++) send(3000, -3000, "R9 build", lo, ro);
    set_ctrl(0, 1, 1, 2'b00);
    send(0, 0, "R3 held", lo, ro);
    d0 = lo;
    check("R3 held estimate nonzero", (d0 < 0) ? 1 : 0, 1);
    send(500, 100, "R3 held", lo, ro);
    d1 = lo - 500;
    check("R3 same offset left", d1, d0);
    send(-700, 100, "R3 held", lo, ro);
    check("R3 same offset again", lo + 700, d0);
  endtask

  task automatic t_clear_pass;
    longint lo, ro;
    set_ctrl(0, 1, 0, 2'b00);
    send(1234, -4321, "R4 R1 pass", lo, ro);
    check("R4 left exact", lo, 1234);
    check("R4 right exact", ro, -4321);
    send(-32768, 32767, "R4 R1 pass extremes", lo, ro);
    check("R4 right extreme", ro, 32767);
    set_ctrl(0, 0, 0, 2'b00);
    send(1234, -4321, "R4 after clear restart", lo, ro);
    check("R4 estimate was cleared", lo, 1234);
  endtask

  task automatic t_side_sel;
    longint lo, ro;
    set_ctrl(1, 0, 0, 2'b00);
    for (int i = 0; i < 1500; i++) send(2000, 2000, "R2 left only", lo, ro);
    check("R2 right passes", ro, 2000);
    check("R2 left filtered", (lo < 1000) ? 1 : 0, 1);
    set_ctrl(1, 1, 0, 2'b00);
    for (int i = 0; i < 1500; i++) send(2000, 2000, "R2 right only", lo, ro);
    check("R2 left passes", lo, 2000);
    check("R2 right filtered", (ro < 1000) ? 1 : 0, 1);
  endtask

  task automatic t_polarity;
    longint lo, ro;
    for (int p = 0; p < 4; p++) begin
      set_ctrl(0, 1, 0, 2'(p));
      send(1234, -567, "R5 pol", lo, ro);
      check("R5 left sign", lo, p[0] ? -1234 : 1234);
      check("R5 right sign", ro, p[1] ? 567 : -567);
    end
  endtask

  task automatic t_saturation;
    longint lo, ro;
    set_ctrl(0, 1, 0, 2'b11);
    send(-32768, 32767, "R6 invert", lo, ro);
    check("R6 left min inverted", lo, 32767);
    check("R6 right max inverted", ro, -32767);
    set_ctrl(0, 0, 0, 2'b00);
    for (int i = 0; i < 3000; i++) send(-30000, -30000, "R6 build", lo, ro);
    set_ctrl(0, 1, 1, 2'b10);
    send(32767, 32767, "R6 sub sat", lo, ro);
    check("R6 left sub saturates", lo, 32767);
    check("R6 right sub sat inverted", ro, -32767);
  endtask

  task automatic t_latency_hold;
    longint lo, ro;
    set_ctrl(0, 1, 0, 2'b00);
    send(111, 222, "R7", lo, ro);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      left_i = 16'(i * 77 - 5); right_i = 16'(-i * 31);
      @(negedge clk);
      check("R8 valid low", valid_o, 0);
      check("R8 left held", left_o, 111);
      check("R8 right held", right_o, 222);
    end
  endtask

  initial begin
    acc_m[0] = 0; acc_m[1] = 0;
    fork
      begin
        #(CLK_PERIOD * 3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_default_filter();
        t_store_hold();
        t_clear_pass();
        t_side_sel();
        t_polarity();
        t_saturation();
        t_latency_hold();
      end
      begin
        repeat (150000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule